// File: doc/BRIEF.md
# Programmable Wait-State Bus Controller

This block runs single accesses on a synchronous external bus shared by memories and peripherals. An internal core port hands it one request at a time. Each request carries a space selector, an address, write data and a direction flag. The block drives the address and a one-hot space select, and opens one address setup clock. It then asserts the read or write strobe for a stretch set by the wait-state count of the selected space. It finishes by returning read data along with a single-clock done pulse.

A control register holds one wait-state field per address space, so slow and fast devices can share the same bus. There are four spaces: two data spaces, a program space and an I/O space. An external wait input lets a slow device stretch any access beyond its programmed count. Write data is driven onto the data bus only while a write is in progress. The drive lasts through one clock after the strobe ends. At all other times the output enable stays low.

Top module: `wsbus_ctrl`

## Requirements
- R1: The wait-state register holds one 4-bit field per space. Space code k (0 = X data, 1 = Y data, 2 = program, 3 = I/O) uses bits [4k+3:4k]. A write with cfg_we loads all fields at once, and cfg_rdata shows the stored value from the next clock.
- R2: After reset, every wait-state field reads 15. bus_rd, bus_wr, bus_doe, bus_sel and rsp_done are low, and req_ready is high.
- R3: An access first spends exactly one setup clock with bus_addr and bus_sel valid and both strobes low. Then bus_rd (read) or bus_wr (write) stays high for 1 + N clocks, where N is the field of the selected space.
- R4: bus_wait held high during the last programmed strobe clock, and during each clock after it, extends the strobe by one clock per such clock.
- R5: Read data on bus_din is captured on the last strobe clock. In the clock after the strobe, rsp_done is high for exactly one clock, with that data on rsp_rdata. rsp_done is never high at any other time.
- R6: For a write, bus_doe is high and bus_dout carries the write data from the setup clock through one clock after bus_wr falls. For a read, bus_doe stays low. bus_rd and bus_wr are never high together.
- R7: The wait count is captured when a request is accepted. A register write during an access changes only later accesses.
- R8: req_ready is high only while no access is in progress. A request is taken on a clock where req_valid and req_ready are both high.
- R9: bus_sel is the one-hot code of the request's space (bit k for space code k) from the setup clock to the end of the access, and zero when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load wait-state register |
| cfg_wdata | input | 16 | New wait-state fields |
| cfg_rdata | output | 16 | Current wait-state fields |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_space | input | 2 | Space code of the request |
| req_addr | input | 16 | Access address |
| req_wdata | input | 24 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 24 | Captured read data |
| bus_addr | output | 16 | External address |
| bus_sel | output | 4 | One-hot space select |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_wait | input | 1 | Device stretch request |
| bus_din | input | 24 | Data bus input |
| bus_dout | output | 24 | Data bus output value |
| bus_doe | output | 1 | Data bus output enable |

## Verification
The bench builds the block with its defaults: a 24-bit data bus, a 16-bit address, four spaces and 4-bit fields. These settings make the full 0 to 15 wait range reachable, including the slowest reset timing of 16 strobe clocks. Zero, small and maximal counts are exercised on every space code. Stretches from the wait input are added to both a zero count and a non-zero count. A register rewrite lands in the middle of a long write, which shows that the count captured at acceptance is the one that governs that access.

// File: rtl/wsbus_pkg.sv
package wsbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } wsb_state_e;

  localparam int SPC_XDATA = 0;
  localparam int SPC_YDATA = 1;
  localparam int SPC_PROG  = 2;
  localparam int SPC_IO    = 3;
endpackage

// File: rtl/wsbus_cfg.sv
module wsbus_cfg #(
  parameter int NUM_SPACES = 4,
  parameter int WS_W       = 4,
  localparam int SP_W      = $clog2(NUM_SPACES),
  localparam int CFG_W     = NUM_SPACES * WS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  input  logic [SP_W-1:0]  look_space,
  output logic [WS_W-1:0]  look_ws
);
  logic [WS_W-1:0] field_q [NUM_SPACES];

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) field_q[g] <= '1;
      else if (we) field_q[g] <= wdata[g*WS_W +: WS_W];
    end
    assign rdata[g*WS_W +: WS_W] = field_q[g];
  end

  assign look_ws = field_q[look_space];

  // R2
  cfg_reset_chk: assert property (@(posedge clk) rst |=> (rdata == '1));
  // R1
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata == $past(wdata)));
endmodule

// File: rtl/wsbus_seq.sv
module wsbus_seq
  import wsbus_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 24,
  parameter int WS_W       = 4,
  parameter int NUM_SPACES = 4,
  localparam int SP_W      = $clog2(NUM_SPACES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SP_W-1:0]   req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [WS_W-1:0]   req_ws,
  input  logic              bus_wait,
  input  logic [DATA_W-1:0] bus_din,
  output wsb_state_e        st_q,
  output logic [SP_W-1:0]   space_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              write_q,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [WS_W-1:0] cnt_q;

  assign req_ready = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      space_q   <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            space_q <= req_space;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            cnt_q   <= req_ws;
            st_q    <= ST_SETUP;
          end
        end
        ST_SETUP: st_q <= ST_STROBE;
        ST_STROBE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!bus_wait) begin
            rsp_done <= 1'b1;
            if (!write_q) rsp_rdata <= bus_din;
            st_q <= write_q ? ST_HOLD : ST_IDLE;
          end
        end
        ST_HOLD: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  wait_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STROBE && bus_wait) |=> (st_q == ST_STROBE));
  // R3
  setup_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == ST_STROBE) |-> $past(st_q == ST_SETUP));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  // R5
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(st_q == ST_STROBE));
  // R6
  hold_write_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) |-> write_q);
endmodule

// File: rtl/wsbus_drv.sv
module wsbus_drv
  import wsbus_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 24,
  parameter int NUM_SPACES = 4,
  localparam int SP_W      = $clog2(NUM_SPACES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  wsb_state_e            st_q,
  input  logic [SP_W-1:0]       space_q,
  input  logic [ADDR_W-1:0]     addr_q,
  input  logic [DATA_W-1:0]     wdata_q,
  input  logic                  write_q,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [NUM_SPACES-1:0] bus_sel,
  output logic                  bus_rd,
  output logic                  bus_wr,
  output logic [DATA_W-1:0]     bus_dout,
  output logic                  bus_doe
);
  logic active;

  assign active   = (st_q != ST_IDLE);
  assign bus_rd   = (st_q == ST_STROBE) && !write_q;
  assign bus_wr   = (st_q == ST_STROBE) && write_q;
  assign bus_doe  = active && write_q;
  assign bus_addr = addr_q;
  assign bus_dout = wdata_q;

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_sel
    assign bus_sel[g] = active && (space_q == SP_W'(g));
  end

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_sel));
  // R6
  doe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_doe) |-> $past(!bus_wr));
  // R6
  rd_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> !bus_doe);
endmodule

// File: rtl/wsbus_ctrl.sv
module wsbus_ctrl
  import wsbus_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 24,
  parameter int WS_W       = 4,
  parameter int NUM_SPACES = 4,
  localparam int SP_W      = $clog2(NUM_SPACES),
  localparam int CFG_W     = NUM_SPACES * WS_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_W-1:0]      cfg_wdata,
  output logic [CFG_W-1:0]      cfg_rdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [SP_W-1:0]       req_space,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  req_write,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [NUM_SPACES-1:0] bus_sel,
  output logic                  bus_rd,
  output logic                  bus_wr,
  input  logic                  bus_wait,
  input  logic [DATA_W-1:0]     bus_din,
  output logic [DATA_W-1:0]     bus_dout,
  output logic                  bus_doe
);
  logic [WS_W-1:0]   sel_ws;
  wsb_state_e        st_q;
  logic [SP_W-1:0]   space_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;

  wsbus_cfg #(.NUM_SPACES(NUM_SPACES), .WS_W(WS_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .look_space(req_space), .look_ws(sel_ws)
  );

  wsbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W),
              .NUM_SPACES(NUM_SPACES)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_ws(sel_ws), .bus_wait(bus_wait),
    .bus_din(bus_din), .st_q(st_q), .space_q(space_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .write_q(write_q), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata)
  );

  wsbus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SPACES(NUM_SPACES)) u_drv (
    .clk(clk), .rst(rst), .st_q(st_q), .space_q(space_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .write_q(write_q), .bus_addr(bus_addr),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_dout(bus_dout), .bus_doe(bus_doe)
  );

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> !req_ready);
endmodule

// File: tb/wsbus_ctrl_bench.sv
`timescale 1ns/1ps
module wsbus_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_space = '0;
  logic [15:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        rsp_done;
  logic [23:0] rsp_rdata;
  logic [15:0] bus_addr;
  logic [3:0]  bus_sel;
  logic        bus_rd, bus_wr, bus_doe;
  logic        bus_wait;
  logic [23:0] bus_din, bus_dout;

  always #2 clk = ~clk;

  function automatic logic [23:0] mem_val(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a};
  endfunction

  assign bus_din = mem_val(bus_addr);

  wsbus_ctrl u_wsbus_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wait(bus_wait), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_doe(bus_doe)
  );

  typedef struct {
    logic [1:0]  sp;
    logic        wr;
    logic [15:0] addr;
    logic [23:0] data;
    int          n;
    int          w;
  } item_t;

  item_t       exp_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] cfg_m = 16'hFFFF;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m = v;
    chk(cfg_rdata == v, "R1 readback", cfg_rdata, v);
  endtask

  task automatic access(input logic [1:0] sp, input logic wr, input logic [15:0] a,
                        input logic [23:0] d, input int w);
    item_t it;
    @(negedge clk);
    it.sp = sp; it.wr = wr; it.addr = a; it.data = d; it.w = w;
    it.n = int'(cfg_m[sp*4 +: 4]);
    exp_q.push_back(it);
    req_space = sp; req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  int    k = 0;
  int    setup_n = 0;
  bit    chk_off = 0;
  item_t cur;

  always @(negedge clk) begin
    if (rst) begin
      k = 0; setup_n = 0; chk_off = 0; bus_wait = 1'b0;
    end else begin
      if (chk_off) begin
        chk(!bus_doe, "R6 release after hold", bus_doe, 0);
        chk_off = 0;
      end
      if (bus_rd || bus_wr) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected strobe", 1, 0);
        end else begin
          cur = exp_q[0];
          k++;
          if (k == 1) begin
            chk(setup_n == 1, "R3 setup clocks", setup_n, 1);
            chk(bus_addr == cur.addr, "R3 address", bus_addr, cur.addr);
            chk(bus_sel == (4'b1 << cur.sp), "R9 select", bus_sel, 4'b1 << cur.sp);
            chk(bus_wr == cur.wr && bus_rd == !cur.wr, "R6 direction", bus_wr, cur.wr);
            chk(bus_doe == cur.wr, "R6 drive during strobe", bus_doe, cur.wr);
            chk(!req_ready, "R8 busy", req_ready, 0);
            chk(!rsp_done, "R5 early done", rsp_done, 0);
          end
          bus_wait = (k >= cur.n + 1) && (k <= cur.n + cur.w);
        end
      end else if (k > 0) begin
        cur = exp_q.pop_front();
        bus_wait = 1'b0;
        if (cur.w > 0) chk(k == 1 + cur.n + cur.w, "R4 stretched length", k, 1 + cur.n + cur.w);
        else           chk(k == 1 + cur.n, "R3 strobe length", k, 1 + cur.n);
        chk(rsp_done, "R5 done pulse", rsp_done, 1);
        if (!cur.wr) begin
          chk(rsp_rdata == mem_val(cur.addr), "R5 read data", rsp_rdata, mem_val(cur.addr));
          chk(!bus_doe, "R6 no drive on read", bus_doe, 0);
        end else begin
          chk(bus_doe, "R6 hold drive", bus_doe, 1);
          chk(bus_dout == cur.data, "R6 write data", bus_dout, cur.data);
          chk_off = 1;
        end
        k = 0; setup_n = 0;
      end else begin
        if (bus_sel != '0) setup_n++;
        if (rsp_done) chk(0, "R5 stray done", 1, 0);
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R2 reset state
    chk(cfg_rdata == 16'hFFFF, "R2 fields", cfg_rdata, 16'hFFFF);
    chk(!bus_rd && !bus_wr, "R2 strobes", {bus_rd, bus_wr}, 0);
    chk(!bus_doe, "R2 drive", bus_doe, 0);
    chk(bus_sel == '0, "R2 select", bus_sel, 0);
    chk(!rsp_done, "R2 done", rsp_done, 0);
    chk(req_ready, "R2 ready", req_ready, 1);
    rst = 1'b0;
    // reset timing: 15 waits
    access(2'd0, 1'b0, 16'h0100, 24'h0, 0);
    access(2'd3, 1'b1, 16'h0101, 24'hABCDEF, 0);
    // R1: X=0 Y=1 P=2 IO=3
    cfg_write(16'h3210);
    for (int s = 0; s < 4; s++) begin
      access(2'(s), 1'b0, 16'h1000 + 16'(s), 24'h0, 0);
      access(2'(s), 1'b1, 16'h2000 + 16'(s), 24'h123400 + 24'(s), 0);
    end
    // R4 stretch on zero and non-zero counts
    access(2'd0, 1'b0, 16'h3000, 24'h0, 2);
    access(2'd3, 1'b1, 16'h3001, 24'h55AA55, 3);
    access(2'd2, 1'b0, 16'h3002, 24'h0, 1);
    // X=5 Y=A P=0 IO=F
    cfg_write(16'hF0A5);
    access(2'd3, 1'b0, 16'h4003, 24'h0, 0);
    access(2'd2, 1'b1, 16'h4002, 24'h00FF00, 0);
    // R7: rewrite during a long write to Y
    access(2'd1, 1'b1, 16'h5001, 24'h987654, 0);
    repeat (2) @(negedge clk);
    cfg_write(16'h1111);
    access(2'd1, 1'b0, 16'h5002, 24'h0, 0);
    // back-to-back reads
    cfg_write(16'h0000);
    access(2'd0, 1'b0, 16'h6000, 24'h0, 0);
    access(2'd1, 1'b0, 16'h6001, 24'h0, 0);
    access(2'd3, 1'b0, 16'hFFFF, 24'h0, 0);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(req_ready && bus_sel == '0, "R9 idle select", bus_sel, 0);
    summary();
    $finish;
  end
endmodule